// File: doc/BRIEF.md
# UART Transmitter with Break and Flow Control

This block is the transmit half of a UART. Software-side logic writes characters into a small queue. A serializer takes them out one at a time and drives them onto the TX line. Each character goes out as a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. The line moves one bit position per cycle of a baud tick strobe, which is supplied from outside. When the queue is empty the line rests high.

Two extra functions sit beside the normal character path. A break request makes the serializer send one frame that stays low for every bit position of the configured format. With flow control enabled, an active-low clear-to-send input holds back new characters. The input is synchronized, and each change of it produces a one-cycle event pulse. A second event pulse reports when the queue drains down onto a programmed threshold.

The serializer is a state machine with six states:
- `ST_IDLE`: line high, waiting.
- `ST_START`: start bit.
- `ST_DATA`: data bits.
- `ST_PAR`: parity bit.
- `ST_STOP`: stop bits.
- `ST_BRK`: break frame.

All transitions happen on a baud tick:
- **launch_break**: `ST_IDLE` or the last stop bit → `ST_BRK`, when a break is pending.
- **launch_char**: `ST_IDLE` or the last stop bit → `ST_START`, when the queue holds data and flow control permits.
- **rest**: last stop bit → `ST_IDLE`, when neither launch applies.
- **begin_data**: `ST_START` → `ST_DATA`.
- **end_data**: `ST_DATA` → `ST_PAR` or `ST_STOP`.
- **end_parity**: `ST_PAR` → `ST_STOP`.
- **second_stop**: `ST_STOP` stays in `ST_STOP` for the second stop bit.
- **end_break**: `ST_BRK` → `ST_IDLE`.

Top module: `uart_tx_core`

## Requirements
- R1: After reset, `tx` is 1, `fifo_level` is 0, and `thr_evt` and `cts_evt` are 0.
- R2: A character frame is one low start bit, then the data bits LSB first, then the stop bit(s) high. Each bit position lasts exactly one `baud_tick` period. `cfg_len` selects the data length: 0 = 5 bits, 1 = 6, 2 = 7, 3 = 8.
- R3: When `cfg_par_en` is 1, a parity bit follows the data bits.
  - With `cfg_par_sense` = 0 the parity bit is 1 when the count of 1s among the data bits is odd.
  - With `cfg_par_sense` = 1 the parity bit is 1 when the count of 0s among the data bits is odd.
- R4: `cfg_stop2` = 1 sends two stop bits; 0 sends one.
- R5: When another character is queued at the end of a frame, its start bit follows the last stop bit with no idle bit between them.
- R6: A one-cycle `brk_req` pulse sends exactly one break frame at the next character boundary.
  - The break frame is low for 1 + data length + parity + stop bit positions.
  - It takes precedence over queued characters and ignores flow control.
  - It is followed by exactly one idle high bit before any queued character starts.
- R7: While `cfg_fc_en` is 1 and the synchronized `cts_n` is 1, no new character starts. A character already started completes. Transmission resumes when `cts_n` returns to 0. When `cfg_fc_en` is 0, `cts_n` has no effect.
- R8: While `cfg_fc_en` is 1, each change of the synchronized `cts_n` produces one one-cycle `cts_evt` pulse. While `cfg_fc_en` is 0, no pulse is produced.
- R9: `fifo_level` counts accepted writes minus characters taken. A write while the level equals DEPTH is dropped, and that character is never sent.
- R10: `thr_evt` pulses for one cycle when `fifo_level` goes from above `cfg_thr` to equal to it. It does not pulse when the level rises to the threshold.
- R11: A write in the same cycle as a character is taken leaves `fifo_level` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle strobe per bit period |
| wr_en | input | 1 | Write strobe for the queue |
| wr_data | input | 8 | Character to queue |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_sense | input | 1 | Parity over 1s (0) or over 0s (1) |
| cfg_len | input | 2 | Data length code, 5 + value bits |
| cfg_stop2 | input | 1 | Two stop bits when 1 |
| cfg_fc_en | input | 1 | Flow control enable |
| brk_req | input | 1 | Break request pulse |
| cfg_thr | input | LVL_W (4) | Queue threshold for `thr_evt` |
| cts_n | input | 1 | Clear to send, active low, asynchronous |
| tx | output | 1 | Serial output line |
| fifo_level | output | LVL_W (4) | Characters in the queue |
| thr_evt | output | 1 | Drain-to-threshold event pulse |
| cts_evt | output | 1 | Clear-to-send change event pulse |

## Verification
The interesting coincidence is a queue write landing on the same clock edge on which the serializer takes a character. The bench provokes it by aligning itself to its own baud tick generator. It writes one character two cycles before a tick, then asserts a second write exactly in the tick cycle while the line is idle. It judges the result by requiring `fifo_level` to read 1 afterwards, not 0 or 2, and by requiring both characters to arrive back to back on the line. A second overlap is a break request and a character write issued together. The bench checks that the break frame comes first and that exactly one idle bit separates it from the character.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int CHAR_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4,
        ST_BRK   = 3'd5
    } tx_state_e;

    // number of data bits for a length code
    function automatic logic [3:0] data_bits(input logic [1:0] code);
        return 4'd5 + {2'b00, code};
    endfunction

    // parity over the 1s (sense=0) or over the 0s (sense=1) of the used bits
    function automatic logic parity_of(input logic [CHAR_W-1:0] d,
                                       input logic [3:0]        nbits,
                                       input logic              sense);
        logic [CHAR_W-1:0] mask;
        mask = {CHAR_W{1'b1}} >> (4'd8 - nbits);
        return sense ? ^(~d & mask) : ^(d & mask);
    endfunction

endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    localparam int LW   = $clog2(DEPTH + 1),
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          pop,
    output logic [DW-1:0] rd_data,
    output logic          empty,
    output logic [LW-1:0] level
);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic [LW-1:0] count;
    logic          push;

    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);
    localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

    assign push    = wr_en && (count != FULL_LVL);
    assign empty   = (count == '0);
    assign level   = count;
    assign rd_data = mem[rptr];

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= (wptr == LAST_PTR) ? '0 : wptr + 1'b1;
            if (pop)  rptr <= (rptr == LAST_PTR) ? '0 : rptr + 1'b1;
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0)); // R9
    AST_LVL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_LVL); // R9
    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> (count == $past(count) + 1'b1)); // R9
    AST_SAME_CYCLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> $stable(count)); // R11

endmodule

// File: rtl/uart_cts_sync.sv
module uart_cts_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_n,
    input  logic fc_en,
    output logic cts_ok,
    output logic cts_evt
);

    logic meta_q, sync_q, prev_q, evt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
            evt_q  <= 1'b0;
        end else begin
            meta_q <= cts_n;
            sync_q <= meta_q;
            prev_q <= sync_q;
            evt_q  <= fc_en && (sync_q != prev_q);
        end
    end

    assign cts_ok  = !sync_q;
    assign cts_evt = evt_q;

    AST_CTS_EVT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        cts_evt |-> $past(fc_en)); // R8
    AST_CTS_EVT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cts_evt |=> !cts_evt); // R8

endmodule

// File: rtl/uart_tx_fsm.sv
module uart_tx_fsm
    import uart_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              brk_req,
    input  logic              fifo_empty,
    input  logic [CHAR_W-1:0] fifo_data,
    input  logic              cts_ok,
    input  logic              cfg_par_en,
    input  logic              cfg_par_sense,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_stop2,
    input  logic              cfg_fc_en,
    output logic              pop,
    output logic              tx
);

    tx_state_e         state, state_n;
    logic [CHAR_W-1:0] shreg, shreg_n;
    logic [3:0]        cnt, cnt_n;
    logic              par_q, par_n;
    logic              stop_q, stop_n;
    logic              brk_pend, brk_clr;
    logic [3:0]        nbits, brk_len;
    logic              may_send;

    assign nbits    = data_bits(cfg_len);
    assign brk_len  = nbits + 4'd2 + {3'b000, cfg_par_en} + {3'b000, cfg_stop2};
    assign may_send = !fifo_empty && (!cfg_fc_en || cts_ok);

    // next state and datapath
    always_comb begin
        state_n = state;
        shreg_n = shreg;
        cnt_n   = cnt;
        par_n   = par_q;
        stop_n  = stop_q;
        pop     = 1'b0;
        brk_clr = 1'b0;
        if (tick) begin
            unique case (state)
                ST_IDLE, ST_STOP: begin
                    if (state == ST_STOP && cfg_stop2 && !stop_q) begin
                        stop_n = 1'b1;                 // second_stop
                    end else if (brk_pend) begin
                        state_n = ST_BRK;              // launch_break
                        cnt_n   = '0;
                    end else if (may_send) begin
                        state_n = ST_START;            // launch_char
                        shreg_n = fifo_data;
                        par_n   = parity_of(fifo_data, nbits, cfg_par_sense);
                        pop     = 1'b1;
                    end else begin
                        state_n = ST_IDLE;             // rest
                    end
                end
                ST_START: begin
                    state_n = ST_DATA;                 // begin_data
                    cnt_n   = '0;
                end
                ST_DATA: begin
                    if (cnt == nbits - 4'd1) begin
                        state_n = cfg_par_en ? ST_PAR : ST_STOP; // end_data
                        stop_n  = 1'b0;
                    end else begin
                        cnt_n   = cnt + 4'd1;
                        shreg_n = shreg >> 1;
                    end
                end
                ST_PAR: begin
                    state_n = ST_STOP;                 // end_parity
                    stop_n  = 1'b0;
                end
                ST_BRK: begin
                    if (cnt == brk_len - 4'd1) begin
                        state_n = ST_IDLE;             // end_break
                        brk_clr = 1'b1;
                    end else begin
                        cnt_n = cnt + 4'd1;
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            shreg    <= '0;
            cnt      <= '0;
            par_q    <= 1'b0;
            stop_q   <= 1'b0;
            brk_pend <= 1'b0;
        end else begin
            state    <= state_n;
            shreg    <= shreg_n;
            cnt      <= cnt_n;
            par_q    <= par_n;
            stop_q   <= stop_n;
            brk_pend <= brk_req | (brk_pend & !brk_clr);
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_START, ST_BRK: tx = 1'b0;
            ST_DATA:          tx = shreg[0];
            ST_PAR:           tx = par_q;
            default:          tx = 1'b1;
        endcase
    end

    AST_MOVE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(state)); // R2
    AST_PAUSE_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state == ST_IDLE && cfg_fc_en && !cts_ok && !brk_pend) |=> (state == ST_IDLE)); // R7
    AST_CHAR_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA) |=> (state inside {ST_DATA, ST_PAR, ST_STOP})); // R7
    AST_BRK_AUTOCLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BRK && tick && cnt == brk_len - 4'd1 && !brk_req) |=> !brk_pend); // R6
    AST_BRK_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BRK && tick && cnt == brk_len - 4'd1) |=> (state == ST_IDLE)); // R6

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core #(
    parameter int DEPTH  = 8,
    localparam int DW    = uart_tx_pkg::CHAR_W,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             baud_tick,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    input  logic             cfg_par_en,
    input  logic             cfg_par_sense,
    input  logic [1:0]       cfg_len,
    input  logic             cfg_stop2,
    input  logic             cfg_fc_en,
    input  logic             brk_req,
    input  logic [LVL_W-1:0] cfg_thr,
    input  logic             cts_n,
    output logic             tx,
    output logic [LVL_W-1:0] fifo_level,
    output logic             thr_evt,
    output logic             cts_evt
);

    logic          pop, empty, cts_ok;
    logic [DW-1:0] head;
    logic [LVL_W-1:0] lvl_prev;

    uart_tx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .pop     (pop),
        .rd_data (head),
        .empty   (empty),
        .level   (fifo_level)
    );

    uart_cts_sync u_cts (
        .clk     (clk),
        .rst_n   (rst_n),
        .cts_n   (cts_n),
        .fc_en   (cfg_fc_en),
        .cts_ok  (cts_ok),
        .cts_evt (cts_evt)
    );

    uart_tx_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (baud_tick),
        .brk_req       (brk_req),
        .fifo_empty    (empty),
        .fifo_data     (head),
        .cts_ok        (cts_ok),
        .cfg_par_en    (cfg_par_en),
        .cfg_par_sense (cfg_par_sense),
        .cfg_len       (cfg_len),
        .cfg_stop2     (cfg_stop2),
        .cfg_fc_en     (cfg_fc_en),
        .pop           (pop),
        .tx            (tx)
    );

    // drain-onto-threshold edge detector
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_prev <= '0;
        else        lvl_prev <= fifo_level;
    end

    assign thr_evt = (lvl_prev > cfg_thr) && (fifo_level == cfg_thr);

    AST_THR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        thr_evt |=> !thr_evt); // R10
    AST_THR_ON_POP: assert property (@(posedge clk) disable iff (!rst_n)
        thr_evt |-> $past(pop)); // R10

endmodule

// File: tb/uart_tx_core_tb.sv
module uart_tx_core_tb;

    localparam int DEPTH = 8;
    localparam int LW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_data = '0;
    logic          cfg_par_en = 1'b0, cfg_par_sense = 1'b0, cfg_stop2 = 1'b0, cfg_fc_en = 1'b0;
    logic [1:0]    cfg_len = 2'd3;
    logic          brk_req = 1'b0;
    logic [LW-1:0] cfg_thr = LW'(DEPTH);
    logic          cts_n = 1'b0;
    logic          tx, thr_evt, cts_evt;
    logic [LW-1:0] fifo_level;
    logic [2:0]    phase = '0;
    logic          baud_tick;

    always #2.5 clk = ~clk;
    always @(posedge clk) phase <= phase + 3'd1;
    assign baud_tick = (phase == 3'd7);

    uart_tx_core #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en), .wr_data(wr_data),
        .cfg_par_en(cfg_par_en), .cfg_par_sense(cfg_par_sense), .cfg_len(cfg_len),
        .cfg_stop2(cfg_stop2), .cfg_fc_en(cfg_fc_en), .brk_req(brk_req), .cfg_thr(cfg_thr),
        .cts_n(cts_n), .tx(tx), .fifo_level(fifo_level), .thr_evt(thr_evt), .cts_evt(cts_evt)
    );

    typedef struct {
        logic [15:0] bits;
        int          n;
        int          gap;
    } item_t;

    item_t sb[$];
    string sb_tag[$];
    int checks = 0, errors = 0;
    int thr_cnt = 0, cts_cnt = 0, frames = 0;
    bit in_frame = 0, done = 0;
    int idle_cnt = 0, nb = 0, gap_seen = 0;
    logic [15:0] cur = '0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic item_t mk(input logic [7:0] d, input bit brk, input int gap);
        item_t it;
        int l;
        logic p;
        l = 5 + int'(cfg_len);
        it.bits = '0;
        it.gap = gap;
        for (int i = 0; i < l; i++) it.bits[1+i] = d[i];
        it.n = 1 + l;
        if (cfg_par_en) begin
            p = 1'b0;
            for (int i = 0; i < l; i++) p = p ^ (cfg_par_sense ? ~d[i] : d[i]);
            it.bits[it.n] = p;
            it.n++;
        end
        it.bits[it.n] = 1'b1;
        it.n++;
        if (cfg_stop2) begin
            it.bits[it.n] = 1'b1;
            it.n++;
        end
        if (brk) it.bits = '0;
        return it;
    endfunction

    task automatic send(input logic [7:0] d, input int gap, input string tag, input bit expect_it);
        if (expect_it) begin
            sb.push_back(mk(d, 1'b0, gap));
            sb_tag.push_back(tag);
        end
        @(negedge clk);
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic drain();
        while (sb.size() != 0 || in_frame) @(negedge clk);
        repeat (40) @(negedge clk);
    endtask

    // event counters
    always @(negedge clk) begin
        if (rst_n && thr_evt) thr_cnt++;
        if (rst_n && cts_evt) cts_cnt++;
    end

    // monitor: samples the line mid-bit and compares whole frames against the scoreboard
    always @(negedge clk) begin
        if (rst_n && phase == 3'd3) begin
            if (!in_frame) begin
                if (tx == 1'b0) begin
                    if (sb.size() == 0) begin
                        chk(1'b0, "R2", "unexpected frame start, tx", 0, 1);
                    end else begin
                        in_frame = 1;
                        cur      = '0;
                        nb       = 1;
                        gap_seen = idle_cnt;
                    end
                end else begin
                    idle_cnt++;
                end
            end else begin
                cur[nb] = tx;
                nb++;
            end
            if (in_frame && nb == sb[0].n) begin
                item_t e;
                string t;
                e = sb.pop_front();
                t = sb_tag.pop_front();
                chk(cur == e.bits, t, "frame bits", int'(cur), int'(e.bits));
                if (e.gap >= 0) chk(gap_seen == e.gap, t, "idle bits before frame", gap_seen, e.gap);
                frames++;
                in_frame = 0;
                idle_cnt = 0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int f0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(tx == 1'b1, "R1", "tx in reset", int'(tx), 1);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(tx == 1'b1, "R1", "tx after reset", int'(tx), 1);
        chk(fifo_level == 0, "R1", "level after reset", int'(fifo_level), 0);
        chk(thr_evt == 1'b0 && cts_evt == 1'b0, "R1", "events after reset", int'({thr_evt, cts_evt}), 0);

        // R2 and R5: 8 bits, no parity, back to back
        send(8'hA5, -1, "R2", 1);
        send(8'h3C, 0, "R5", 1);
        drain();

        // R3 parity over ones, 5 bits
        cfg_len = 2'd0; cfg_par_en = 1'b1; cfg_par_sense = 1'b0;
        send(8'h13, -1, "R3", 1);
        drain();
        // R3 parity over zeros, 7 bits
        cfg_len = 2'd2; cfg_par_sense = 1'b1;
        send(8'h5B, -1, "R3", 1);
        send(8'h7F, 0, "R3", 1);
        drain();
        // R4 two stop bits, 6 bits, no parity
        cfg_len = 2'd1; cfg_par_en = 1'b0; cfg_stop2 = 1'b1;
        send(8'h2D, -1, "R4", 1);
        send(8'h12, 0, "R4", 1);
        drain();

        // R6 break together with a queued character
        cfg_len = 2'd3; cfg_stop2 = 1'b0;
        sb.push_back(mk(8'h00, 1'b1, -1)); sb_tag.push_back("R6");
        sb.push_back(mk(8'h55, 1'b0, 1));  sb_tag.push_back("R6");
        @(negedge clk);
        brk_req = 1'b1; wr_data = 8'h55; wr_en = 1'b1;
        @(negedge clk);
        brk_req = 1'b0; wr_en = 1'b0;
        drain();
        // R6 break length with parity and two stops, sent once
        cfg_par_en = 1'b1; cfg_stop2 = 1'b1;
        sb.push_back(mk(8'h00, 1'b1, -1)); sb_tag.push_back("R6");
        @(negedge clk); brk_req = 1'b1;
        @(negedge clk); brk_req = 1'b0;
        drain();
        f0 = frames;
        repeat (300) @(negedge clk);
        chk(frames == f0 && tx == 1'b1, "R6", "frames after single break", frames - f0, 0);
        cfg_par_en = 1'b0; cfg_stop2 = 1'b0;

        // R7 and R8 flow control
        cfg_fc_en = 1'b1;
        repeat (10) @(negedge clk);
        cts_cnt = 0;
        cts_n = 1'b1;
        repeat (10) @(negedge clk);
        f0 = frames;
        send(8'hC3, -1, "R7", 1);
        send(8'h81, -1, "R7", 1);
        repeat (200) @(negedge clk);
        chk(fifo_level == 2, "R7", "level while paused", int'(fifo_level), 2);
        chk(frames == f0 && !in_frame, "R7", "frames while paused", frames - f0, 0);
        cts_n = 1'b0;
        while (!in_frame) @(negedge clk);
        cts_n = 1'b1;
        repeat (400) @(negedge clk);
        chk(frames == f0 + 1, "R7", "character in progress completed", frames - f0, 1);
        chk(fifo_level == 1, "R7", "second character held", int'(fifo_level), 1);
        cts_n = 1'b0;
        drain();
        chk(cts_cnt == 4, "R8", "cts events with flow control", cts_cnt, 4);

        // R7 and R8 flow control disabled
        cfg_fc_en = 1'b0;
        repeat (5) @(negedge clk);
        cts_cnt = 0;
        cts_n = 1'b1; repeat (20) @(negedge clk);
        cts_n = 1'b0; repeat (20) @(negedge clk);
        cts_n = 1'b1; repeat (20) @(negedge clk);
        send(8'h6E, -1, "R7", 1);
        drain();
        chk(cts_cnt == 0, "R8", "cts events without flow control", cts_cnt, 0);
        cts_n = 1'b0;

        // R10 threshold on drain only
        cfg_fc_en = 1'b1; cts_n = 1'b1; cfg_thr = LW'(2);
        repeat (20) @(negedge clk);
        thr_cnt = 0;
        for (int i = 0; i < 4; i++) send(8'(8'h40 + i), (i == 0) ? -1 : 0, "R10", 1);
        repeat (5) @(negedge clk);
        chk(fifo_level == 4, "R10", "level after four writes", int'(fifo_level), 4);
        chk(thr_cnt == 0, "R10", "events while filling", thr_cnt, 0);
        cts_n = 1'b0;
        drain();
        chk(thr_cnt == 1, "R10", "events while draining", thr_cnt, 1);

        // R9 overflow drops writes
        cfg_thr = LW'(DEPTH);
        cts_n = 1'b1;
        repeat (20) @(negedge clk);
        f0 = frames;
        for (int i = 0; i < DEPTH + 2; i++) send(8'(i * 17 + 1), (i == 0) ? -1 : 0, "R9", i < DEPTH);
        repeat (5) @(negedge clk);
        chk(fifo_level == DEPTH, "R9", "level when full", int'(fifo_level), DEPTH);
        cts_n = 1'b0;
        drain();
        chk(frames - f0 == DEPTH, "R9", "frames sent after overflow", frames - f0, DEPTH);
        chk(fifo_level == 0, "R9", "level after drain", int'(fifo_level), 0);

        // R11 write in the same cycle as a take
        cfg_fc_en = 1'b0;
        repeat (20) @(negedge clk);
        sb.push_back(mk(8'h99, 1'b0, -1)); sb_tag.push_back("R11");
        sb.push_back(mk(8'h66, 1'b0, 0));  sb_tag.push_back("R11");
        do @(negedge clk); while (phase != 3'd5);
        wr_data = 8'h99; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        wr_data = 8'h66; wr_en = 1'b1;   // baud tick cycle
        @(negedge clk);
        wr_en = 1'b0;
        chk(fifo_level == 1, "R11", "level after write with take", int'(fifo_level), 1);
        drain();

        repeat (200) @(negedge clk);
        chk(sb.size() == 0, "R2", "scoreboard left over", sb.size(), 0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule